// File: doc/BRIEF.md
# Quiet-Gap Run-Length Sample Compressor

This block takes a stream of 8-bit samples and turns it into 16-bit words for a host. Each word holds two bytes. Stretches of signal that show activity pass through as literal sample pairs. Long unmodulated stretches are dropped, and marker words take their place. A marker records exactly how many samples were removed, so the host can rebuild the original sample timeline.

The byte value 0x00 serves as an in-band escape. Incoming zero samples are raised to 0x01, so a zero first byte always marks a skip record. A small activity detector decides which samples are quiet. It compares each sample with a baseline that creeps toward the signal one step per sample. A skip run begins only after a configurable number of consecutive quiet samples. Output words queue in a small FIFO that has a valid/ready interface. A sticky flag reports any word lost because that FIFO was full.

Top module: `qgc_top`

## Requirements
- R1: A sample of value 0x00 is handled as 0x01, both by the detector and in literal output, so a literal byte is never 0x00.
- R2: Literal samples are packed two per word in arrival order: the earlier sample goes in outData[15:8] and the later one in outData[7:0].
- R3: A skip record is a word with outData[15:8] = 0x00 and outData[7:0] = (number of skipped samples − 1).
- R4: When the skip count reaches 256, the record 0x00FF is pushed at once in the cycle of the 256th skipped sample, and counting restarts from zero. A gap of 300 skipped samples therefore yields 0x00FF and then 0x002B.
- R5: The baseline resets to 0x80. Each accepted sample moves it one step toward that sample. A sample is quiet when |sample − baseline| ≤ cfgThreshold, using the baseline from before that sample's update.
- R6: A counter of consecutive quiet samples clears on any non-quiet sample and saturates at 255. A quiet sample is eligible for skipping only when the counter, before this sample, is ≥ cfgQuietLen. Samples that are not eligible are emitted as literals.
- R7: If a literal byte is waiting for its partner when an eligible quiet sample arrives, that sample completes the pair as a literal and is not counted as skipped. Skip records therefore always start on a word boundary.
- R8: A non-quiet sample ends a skip run. A record for the partial count (if it is nonzero) is pushed in that sample's cycle, and the sample itself becomes the next literal byte.
- R9: A word is pushed at the clock edge that accepts its sample and appears on outValid/outData after that edge. Words leave in push order. A word that is offered but not accepted stays unchanged until outReady is high.
- R10: If a word must be pushed while the FIFO already holds FIFO_DEPTH words, that word is dropped and overflow goes high. overflow stays high until reset.
- R11: While rst_n is low, and after it is released, outValid and overflow are 0 until a word is pushed or lost.
- R12: In a cycle with sampleValid low, no word is produced and the detector state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | sampleData holds a sample this cycle |
| sampleData | input | 8 | Incoming sample |
| cfgThreshold | input | 8 | Largest distance from the baseline that still counts as quiet |
| cfgQuietLen | input | 8 | Number of consecutive quiet samples needed before skipping starts |
| outValid | output | 1 | outData holds a word |
| outReady | input | 1 | Host accepts the word this cycle |
| outData | output | 16 | Literal pair or skip record |
| overflow | output | 1 | Sticky flag: a word was lost to a full FIFO |

## Verification
Every sample is handled at the edge that accepts it. The word it produces, if any, is visible on outValid/outData from the following half cycle, and overflow rises at the same edge. The bench drives inputs on the falling edge. It advances a behavioural queue model on each rising edge and compares the FIFO head, valid and overflow a little after each falling edge, one full cycle after the stimulus. Directed scenarios then read the accepted-word log for exact sequences at the detector threshold, at the quiet-length start, at odd-pairing and at the 256 boundary.

// File: rtl/qgc_pkg.sv
package qgc_pkg;

  // Strobes passed from the sequencing control to the datapath
  typedef struct packed {
    logic track;       // accepted sample: move baseline
    logic latchPend;   // hold sample as the first byte of a pair
    logic pushPair;    // push {pending byte, sample}
    logic pushMarker;  // push record for partial skip count
    logic pushFullRun; // push record for a 256-sample skip
    logic incRun;      // count sample as skipped
    logic clearRun;    // restart skip count
  } qgc_strobe_t;

endpackage

// File: rtl/qgc_ctrl.sv
module qgc_ctrl
  import qgc_pkg::*;
#(
  parameter int STREAK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic                isQuiet,
  input  logic                runNonZero,
  input  logic                runTop,
  input  logic [STREAK_W-1:0] cfgQuietLen,
  output qgc_strobe_t         strb
);

  localparam logic [STREAK_W-1:0] STREAK_MAX = '1;

  logic [STREAK_W-1:0] streak;
  logic                pendFlag;
  logic                eligible;

  assign eligible = (streak >= cfgQuietLen);

  always_comb begin
    strb = '0;
    if (sampleValid) begin
      strb.track = 1'b1;
      if (!isQuiet || !eligible) begin
        if (!isQuiet && runNonZero) begin
          strb.pushMarker = 1'b1;
          strb.clearRun   = 1'b1;
        end
        if (pendFlag) strb.pushPair  = 1'b1;
        else          strb.latchPend = 1'b1;
      end else if (pendFlag) begin
        strb.pushPair = 1'b1;
      end else if (runTop) begin
        strb.pushFullRun = 1'b1;
        strb.clearRun    = 1'b1;
      end else begin
        strb.incRun = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streak   <= '0;
      pendFlag <= 1'b0;
    end else if (sampleValid) begin
      if (!isQuiet)                streak <= '0;
      else if (streak != STREAK_MAX) streak <= streak + 1'b1;
      if (strb.latchPend)     pendFlag <= 1'b1;
      else if (strb.pushPair) pendFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/qgc_datapath.sv
module qgc_datapath
  import qgc_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SAMPLE_W-1:0]   sampleData,
  input  logic [SAMPLE_W-1:0]   cfgThreshold,
  input  qgc_strobe_t           strb,
  input  logic                  outReady,
  output logic                  isQuiet,
  output logic                  runNonZero,
  output logic                  runTop,
  output logic                  outValid,
  output logic [2*SAMPLE_W-1:0] outData,
  output logic                  overflow
);

  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam logic [SAMPLE_W-1:0] BASE_INIT = SAMPLE_W'(1) << (SAMPLE_W - 1);
  localparam logic [CNT_W-1:0]    CNT_FULL  = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0]    PTR_LAST  = PTR_W'(FIFO_DEPTH - 1);

  logic [SAMPLE_W-1:0] sampleFix, baseline, distance, pendByte, runCnt;
  logic [WORD_W-1:0]   pushWord;
  logic                push, pushEff, pop, full;
  logic [WORD_W-1:0]   mem [FIFO_DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0]    count;

  // zero is reserved for skip records
  assign sampleFix = (sampleData == '0) ? SAMPLE_W'(1) : sampleData;
  assign distance  = (sampleFix >= baseline) ? (sampleFix - baseline)
                                             : (baseline - sampleFix);
  assign isQuiet   = (distance <= cfgThreshold);
  assign runNonZero = (runCnt != '0);
  assign runTop     = (runCnt == '1);

  always_comb begin
    pushWord = '0;
    if (strb.pushPair)         pushWord = {pendByte, sampleFix};
    else if (strb.pushMarker)  pushWord = {{SAMPLE_W{1'b0}}, runCnt - 1'b1};
    else if (strb.pushFullRun) pushWord = {{SAMPLE_W{1'b0}}, {SAMPLE_W{1'b1}}};
  end

  assign push    = strb.pushPair | strb.pushMarker | strb.pushFullRun;
  assign full    = (count == CNT_FULL);
  assign pushEff = push & ~full;
  assign outValid = (count != '0);
  assign pop     = outValid & outReady;
  assign outData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseline <= BASE_INIT;
      pendByte <= '0;
      runCnt   <= '0;
    end else begin
      if (strb.track) begin
        if (sampleFix > baseline)      baseline <= baseline + 1'b1;
        else if (sampleFix < baseline) baseline <= baseline - 1'b1;
      end
      if (strb.latchPend) pendByte <= sampleFix;
      if (strb.clearRun)    runCnt <= '0;
      else if (strb.incRun) runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pushEff) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)     rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(pushEff) - CNT_W'(pop);
      if (push && full) overflow <= 1'b1;
    end
  end

  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                 mem[i] <= '0;
      else if (pushEff && (wrPtr == PTR_W'(i)))   mem[i] <= pushWord;
    end
  end

endmodule

// File: rtl/qgc_top.sv
module qgc_top
  import qgc_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int STREAK_W   = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sampleValid,
  input  logic [SAMPLE_W-1:0]   sampleData,
  input  logic [SAMPLE_W-1:0]   cfgThreshold,
  input  logic [STREAK_W-1:0]   cfgQuietLen,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [2*SAMPLE_W-1:0] outData,
  output logic                  overflow
);

  qgc_strobe_t strb;
  logic        isQuiet, runNonZero, runTop;

  qgc_ctrl #(.STREAK_W(STREAK_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .isQuiet(isQuiet),
    .runNonZero(runNonZero), .runTop(runTop), .cfgQuietLen(cfgQuietLen),
    .strb(strb)
  );

  qgc_datapath #(.SAMPLE_W(SAMPLE_W), .FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rst_n(rst_n), .sampleData(sampleData), .cfgThreshold(cfgThreshold),
    .strb(strb), .outReady(outReady), .isQuiet(isQuiet), .runNonZero(runNonZero),
    .runTop(runTop), .outValid(outValid), .outData(outData), .overflow(overflow)
  );

endmodule

// File: rtl/qgc_checker.sv
module qgc_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sampleValid,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic              overflow
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outData));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |=> !outValid && !overflow);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid && !(outValid && outReady)
      |=> $stable(outValid) && $stable(outData) && $stable(overflow));

endmodule

bind qgc_top qgc_checker #(.WORD_W(2*SAMPLE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .outValid(outValid),
  .outReady(outReady), .outData(outData), .overflow(overflow)
);

// File: tb/qgc_top_tb.sv
module qgc_top_tb_top;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [7:0]  sampleData = '0;
  logic [7:0]  cfgThreshold = 8'd8;
  logic [7:0]  cfgQuietLen = 8'd4;
  logic        outReady = 1'b1;
  logic        outValid;
  logic [15:0] outData;
  logic        overflow;

  int vectors = 0;
  int miscomp = 0;
  int cycles  = 0;
  string curReq = "R11";

  always #10 clk = ~clk;

  qgc_top dut_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
    .cfgThreshold(cfgThreshold), .cfgQuietLen(cfgQuietLen), .outValid(outValid),
    .outReady(outReady), .outData(outData), .overflow(overflow)
  );

  // behavioural reference
  logic [15:0] mq[$];
  logic [15:0] popLog[$];
  int  mBase, mStreak, mRun, mPendByte;
  bit  mPend, mOvf;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      mBase = 128; mStreak = 0; mRun = 0; mPendByte = 0; mPend = 0; mOvf = 0;
    end else begin
      int sizeBefore;
      bit hasWord;
      logic [15:0] w;
      sizeBefore = mq.size();
      if (sizeBefore > 0 && outReady) void'(mq.pop_front());
      hasWord = 0; w = '0;
      if (sampleValid) begin
        int s, d;
        bit quiet, elig, lit;
        s = (sampleData == 0) ? 1 : int'(sampleData);
        d = (s > mBase) ? s - mBase : mBase - s;
        quiet = (d <= int'(cfgThreshold));
        if (s > mBase) mBase++; else if (s < mBase) mBase--;
        lit = 0;
        if (!quiet) begin
          mStreak = 0;
          if (mRun > 0) begin hasWord = 1; w = 16'(mRun - 1); mRun = 0; end
          lit = 1;
        end else begin
          elig = (mStreak >= int'(cfgQuietLen));
          if (mStreak < 255) mStreak++;
          if (!elig) lit = 1;
          else if (mPend) begin
            hasWord = 1; w = {8'(mPendByte), 8'(s)}; mPend = 0;
          end else begin
            mRun++;
            if (mRun == 256) begin hasWord = 1; w = 16'h00FF; mRun = 0; end
          end
        end
        if (lit) begin
          if (mPend) begin hasWord = 1; w = {8'(mPendByte), 8'(s)}; mPend = 0; end
          else begin mPendByte = s; mPend = 1; end
        end
      end
      if (hasWord) begin
        if (sizeBefore == DEPTH) mOvf = 1;
        else mq.push_back(w);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  endtask

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #2;
    cycles++;
    if (rst_n) begin
      bit expV;
      expV = (mq.size() != 0);
      vectors++;
      if (outValid !== expV || overflow !== mOvf || (expV && outData !== mq[0])) begin
        miscomp++;
        $display("FAIL %s: valid=%0b data=%h ovf=%0b expected valid=%0b data=%h ovf=%0b",
                 curReq, outValid, outData, overflow, expV,
                 expV ? mq[0] : 16'h0, mOvf);
      end
      if (outValid && outReady) popLog.push_back(outData);
    end
    if (cycles > 150000) begin
      miscomp++;
      $display("FAIL watchdog: run hung, cycles=%0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic feed(input logic [7:0] d);
    @(negedge clk); sampleValid = 1'b1; sampleData = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); sampleValid = 1'b0; end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0; sampleValid = 1'b0; outReady = 1'b1;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    #3;
  endtask

  task automatic checkWord(input string req, input int idx, input logic [15:0] exp);
    vectors++;
    if (idx >= popLog.size() || popLog[idx] !== exp) begin
      miscomp++;
      $display("FAIL %s: word %0d actual %h expected %h", req, idx,
               (idx < popLog.size()) ? popLog[idx] : 16'hxxxx, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    int seed;
    seed = 7;
    // R11: reset state
    idle(3);
    checkBit("R11 valid in reset", outValid, 1'b0);
    checkBit("R11 overflow in reset", overflow, 1'b0);
    doReset();
    checkBit("R11 valid after reset", outValid, 1'b0);

    // R1, R2: zero remap and pair order
    curReq = "R1/R2";
    popLog.delete();
    feed(8'h00); feed(8'h40); feed(8'hC0); feed(8'h00);
    idle(6);
    checkWord("R1 R2 zero remap, first in high byte", 0, 16'h0140);
    checkWord("R1 R2 second pair", 1, 16'hC001);

    // R6, R7, R3, R8: qlen 2 with odd pending at run start
    doReset();
    curReq = "R7";
    cfgQuietLen = 8'd2; cfgThreshold = 8'd8;
    popLog.delete();
    feed(8'h30); feed(8'h80); feed(8'h80); feed(8'h80);
    feed(8'h80); feed(8'h80); feed(8'h80);
    feed(8'h20); feed(8'h50);
    idle(6);
    checkWord("R6 literals before quiet length", 0, 16'h3080);
    checkWord("R7 odd byte paired, not counted", 1, 16'h8080);
    checkWord("R3 R8 partial record of 3", 2, 16'h0002);
    checkWord("R8 breaking sample as literal", 3, 16'h2050);

    // R5: threshold boundary
    doReset();
    curReq = "R5";
    cfgQuietLen = 8'd0; cfgThreshold = 8'd8;
    popLog.delete();
    feed(8'h88); feed(8'h89); feed(8'h8B); feed(8'h10);
    idle(6);
    checkWord("R5 distance 8 quiet, 9 not", 0, 16'h0001);
    checkWord("R5 literal after break", 1, 16'h8B10);

    // R4: 300-sample gap
    doReset();
    curReq = "R4";
    popLog.delete();
    for (int i = 0; i < 300; i++) feed(8'h80);
    feed(8'h10); feed(8'h20);
    idle(6);
    checkWord("R4 full record at 256", 0, 16'h00FF);
    checkWord("R4 remainder 44", 1, 16'h002B);
    checkWord("R4 literal after gap", 2, 16'h1020);

    // R9: random traffic with backpressure
    doReset();
    curReq = "R9";
    cfgQuietLen = 8'd3; cfgThreshold = 8'd6;
    for (int i = 0; i < 4000; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'hFFFF;
      @(negedge clk);
      outReady = ((r & 3) != 0);
      sampleValid = ((r & 8'h30) != 8'h30);
      if (((i / 64) % 2) == 0) sampleData = 8'(8'h7C + ((r >> 6) & 7));
      else                     sampleData = 8'(r >> 4);
    end
    idle(20);

    // R10: overflow and stickiness
    doReset();
    curReq = "R10";
    cfgQuietLen = 8'd4; cfgThreshold = 8'd8;
    @(negedge clk); outReady = 1'b0;
    for (int i = 0; i < 12; i++) feed((i % 2) ? 8'hF0 : 8'h10);
    idle(2);
    checkBit("R10 overflow set", overflow, 1'b1);
    checkBit("R10 fifo holds words", outValid, 1'b1);
    @(negedge clk); outReady = 1'b1;
    idle(10);
    checkBit("R10 overflow held", overflow, 1'b1);
    doReset();
    checkBit("R11 overflow cleared by reset", overflow, 1'b0);

    // R12: idle cycles leave output alone
    curReq = "R12";
    @(negedge clk); outReady = 1'b0;
    feed(8'h10); feed(8'hF0);
    idle(8);
    checkBit("R12 single word held", outValid, 1'b1);
    @(negedge clk); outReady = 1'b1;
    idle(4);
    checkBit("R12 drained", outValid, 1'b0);

    summary();
  end

endmodule